// File: doc/BRIEF.md
# Tile INT8 Matrix Multiply-Accumulate Engine

This engine performs an accumulating integer matrix product on tile operands held in an external bank of eight tile registers: C := C + A × B. A is 16 rows by 64 signed 8-bit elements. B is 64 rows by 16 columns of signed 8-bit elements. C is 16 rows by 16 columns of signed 32-bit accumulators. Every tile row is 512 bits wide. A 3-bit index selects each operand tile. A single start pulse captures the three indices and begins the operation.

The engine first copies all of B into a local buffer over 16 cycles. It then sweeps the output one row per cycle. For row r it reads row r of A and row r of C, forms 16 dot products of length 64 with 1024 parallel multipliers, and writes the updated row r of C one cycle later.

The tile bank ports are synchronous register-file ports, not streams. Reads are combinational with no side effects. The bank must accept one row write in every cycle that `c_wr_en` is high; there is no back-pressure, so the 16-cycle sweep never stalls. `busy` and `done` are plain status levels and pulses.

Top module: `tile_mma_int8`

## Requirements
- R1: During and directly after reset, `busy`, `done` and `c_wr_en` are low.
- R2: When `start` is high while `busy` is low, the engine takes `sel_a`, `sel_b` and `sel_c` and raises `busy` in the following cycle. Later changes on the select inputs have no effect on that operation.
- R3: A `start` pulse while `busy` is high is ignored. No extra writes occur, the tile it names stays unchanged, and the running operation's target does not change.
- R4: Operand layout. Byte j of A row n holds A[n][j]. Byte 4m+i of B tile row k holds B[4k+i][m]. Bits 32m+31..32m of C row n hold C[n][m].
- R5: Each C[n][m] gains the sum over j = 0..63 of A[n][j]·B[j][m]. Operands are signed two's complement and sign-extended before the multiply.
- R6: The 32-bit accumulate wraps modulo 2^32, with no saturation.
- R7: C is written only to tile `sel_c`, in 16 consecutive `c_wr_en` cycles, rows 0 through 15 in ascending order. The first write is 17 cycles after the accepting edge.
- R8: `done` is high for exactly one cycle. It rises 33 clock edges after the accepting edge, which is the cycle after the last row is committed, and `busy` is already low in that cycle.
- R9: A read of row r of A or C happens before row r of C is written. The result is therefore correct when A and C name the same tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| sel_a | input | 3 | Tile index of A |
| sel_b | input | 3 | Tile index of B |
| sel_c | input | 3 | Tile index of C (read and written) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_rd_tile | output | 3 | A read tile index |
| a_rd_row | output | 4 | A read row |
| a_rd_data | input | 512 | A row data |
| b_rd_tile | output | 3 | B read tile index |
| b_rd_row | output | 4 | B read row |
| b_rd_data | input | 512 | B row data |
| c_rd_tile | output | 3 | C read tile index |
| c_rd_row | output | 4 | C read row |
| c_rd_data | input | 512 | C row data |
| c_wr_en | output | 1 | C row write strobe |
| c_wr_tile | output | 3 | C write tile index |
| c_wr_row | output | 4 | C write row |
| c_wr_data | output | 512 | Updated C row |

## Verification
The bench targets operands of all -128 and all +127, and a mixed -128 × +127 case. An engine that zero-extended the bytes would produce large positive sums where negative ones are expected. It also drives a C preload of 0x7FFFFFFF that must wrap to 0x800FC03F; an engine that saturated the accumulate would stay at 0x7FFFFFFF. A case where A and C name the same tile catches any schedule that writes a row before reading it, because A would then be corrupted mid-sweep. A start pulse in the middle of an operation, aimed at another tile, catches an engine that restarts or retargets: extra or misdirected row writes would reach the scoreboard, and the untouched tile would change.

// File: rtl/tmma_pkg.sv
package tmma_pkg;
  localparam int TILE_ROWS  = 16;
  localparam int RED_K      = 64;
  localparam int OUT_COLS   = 16;
  localparam int ELEM_W     = 8;
  localparam int ACC_W      = 32;
  localparam int TILE_IDX_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOADB = 2'd1,
    ST_SWEEP = 2'd2,
    ST_FLUSH = 2'd3
  } tmma_state_e;
endpackage

// File: rtl/tmma_dot.sv
// One output column: signed dot product of an A row against a gathered B column.
module tmma_dot #(
  parameter int K  = tmma_pkg::RED_K,
  parameter int EW = tmma_pkg::ELEM_W,
  parameter int AW = tmma_pkg::ACC_W
) (
  input  logic [K*EW-1:0] a_vec,
  input  logic [K*EW-1:0] b_vec,
  output logic [AW-1:0]   dot
);
  always_comb begin
    logic signed [2*EW-1:0] prod;
    logic signed [AW-1:0]   sum;
    sum = '0;
    for (int k = 0; k < K; k++) begin
      prod = $signed(a_vec[k*EW +: EW]) * $signed(b_vec[k*EW +: EW]);
      sum  = sum + AW'(prod);
    end
    dot = sum;
  end
endmodule

// File: rtl/tmma_bbuf.sv
// Holds all of B and presents it as per-column vectors (R4 packing).
module tmma_bbuf #(
  parameter int K    = tmma_pkg::RED_K,
  parameter int EW   = tmma_pkg::ELEM_W,
  parameter int AW   = tmma_pkg::ACC_W,
  parameter int COLS = tmma_pkg::OUT_COLS,
  localparam int PACK  = AW / EW,
  localparam int BROWS = K / PACK,
  localparam int BRW   = $clog2(BROWS),
  localparam int ROW_W = COLS * PACK * EW
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [BRW-1:0]              wr_idx,
  input  logic [ROW_W-1:0]            wr_data,
  output logic [COLS-1:0][K*EW-1:0]   cols
);
  logic [ROW_W-1:0] mem [BROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar m = 0; m < COLS; m++) begin : g_col
    for (genvar k = 0; k < K; k++) begin : g_red
      assign cols[m][k*EW +: EW] = mem[k / PACK][(m*PACK + (k % PACK))*EW +: EW];
    end
  end
endmodule

// File: rtl/tmma_seq.sv
// Control: idle -> load B rows -> sweep output rows -> flush last write.
module tmma_seq #(
  parameter int ROWS  = tmma_pkg::TILE_ROWS,
  parameter int BROWS = tmma_pkg::TILE_ROWS,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          load_en,
  output logic          sweep_en,
  output logic          done,
  output logic [CW-1:0] cnt
);
  import tmma_pkg::*;
  tmma_state_e state_q;

  always_comb begin
    accept   = start && (state_q == ST_IDLE);
    busy     = (state_q != ST_IDLE);
    load_en  = (state_q == ST_LOADB);
    sweep_en = (state_q == ST_SWEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state_q == ST_FLUSH);
      case (state_q)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state_q <= ST_LOADB;
        end
        ST_LOADB: begin
          if (cnt == CW'(BROWS - 1)) begin
            cnt     <= '0;
            state_q <= ST_SWEEP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SWEEP: begin
          if (cnt == CW'(ROWS - 1)) begin
            cnt     <= '0;
            state_q <= ST_FLUSH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_mma_int8.sv
module tile_mma_int8 #(
  parameter int ROWS = tmma_pkg::TILE_ROWS,
  parameter int K    = tmma_pkg::RED_K,
  parameter int COLS = tmma_pkg::OUT_COLS,
  parameter int EW   = tmma_pkg::ELEM_W,
  parameter int AW   = tmma_pkg::ACC_W,
  parameter int TW   = tmma_pkg::TILE_IDX_W,
  localparam int PACK   = AW / EW,
  localparam int BROWS  = K / PACK,
  localparam int RW     = $clog2(ROWS),
  localparam int BRW    = $clog2(BROWS),
  localparam int CW     = (RW > BRW) ? RW : BRW,
  localparam int ROW_W  = K * EW,
  localparam int CROW_W = COLS * AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TW-1:0]     sel_a,
  input  logic [TW-1:0]     sel_b,
  input  logic [TW-1:0]     sel_c,
  output logic              busy,
  output logic              done,
  output logic [TW-1:0]     a_rd_tile,
  output logic [RW-1:0]     a_rd_row,
  input  logic [ROW_W-1:0]  a_rd_data,
  output logic [TW-1:0]     b_rd_tile,
  output logic [BRW-1:0]    b_rd_row,
  input  logic [CROW_W-1:0] b_rd_data,
  output logic [TW-1:0]     c_rd_tile,
  output logic [RW-1:0]     c_rd_row,
  input  logic [CROW_W-1:0] c_rd_data,
  output logic              c_wr_en,
  output logic [TW-1:0]     c_wr_tile,
  output logic [RW-1:0]     c_wr_row,
  output logic [CROW_W-1:0] c_wr_data
);
  logic          accept, load_en, sweep_en;
  logic [CW-1:0] cnt;
  logic [TW-1:0] ta_q, tb_q, tc_q;

  tmma_seq #(.ROWS(ROWS), .BROWS(BROWS), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .load_en(load_en), .sweep_en(sweep_en), .done(done), .cnt(cnt)
  );

  // Operand selection is frozen at acceptance (R2, R3).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q <= '0;
      tb_q <= '0;
      tc_q <= '0;
    end else if (accept) begin
      ta_q <= sel_a;
      tb_q <= sel_b;
      tc_q <= sel_c;
    end
  end

  assign a_rd_tile = ta_q;
  assign b_rd_tile = tb_q;
  assign c_rd_tile = tc_q;
  assign a_rd_row  = RW'(cnt);
  assign c_rd_row  = RW'(cnt);
  assign b_rd_row  = BRW'(cnt);

  logic [COLS-1:0][ROW_W-1:0] bcols;

  tmma_bbuf #(.K(K), .EW(EW), .AW(AW), .COLS(COLS)) u_bbuf (
    .clk(clk), .wr_en(load_en), .wr_idx(BRW'(cnt)), .wr_data(b_rd_data), .cols(bcols)
  );

  logic [CROW_W-1:0] new_row;

  for (genvar m = 0; m < COLS; m++) begin : g_dot
    logic [AW-1:0] dot_m;
    tmma_dot #(.K(K), .EW(EW), .AW(AW)) u_dot (
      .a_vec(a_rd_data), .b_vec(bcols[m]), .dot(dot_m)
    );
    assign new_row[m*AW +: AW] = c_rd_data[m*AW +: AW] + dot_m;
  end

  // Registered write-back: row r read in sweep cycle r is written one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wr_en   <= 1'b0;
      c_wr_row  <= '0;
      c_wr_data <= '0;
    end else begin
      c_wr_en <= sweep_en;
      if (sweep_en) begin
        c_wr_row  <= RW'(cnt);
        c_wr_data <= new_row;
      end
    end
  end

  assign c_wr_tile = tc_q;
endmodule

// File: rtl/tmma_chk.sv
module tmma_chk #(
  parameter int TW   = tmma_pkg::TILE_IDX_W,
  parameter int RW   = $clog2(tmma_pkg::TILE_ROWS),
  parameter int ROWS = tmma_pkg::TILE_ROWS
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          c_wr_en,
  input logic [TW-1:0] c_wr_tile,
  input logic [RW-1:0] c_wr_row
);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !done && !c_wr_en));

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(c_wr_tile));

  assert_write_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_en && c_wr_row != RW'(ROWS - 1)) |=> (c_wr_en && c_wr_row == $past(c_wr_row) + 1'b1));

  assert_write_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |-> busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !c_wr_en));
endmodule

bind tile_mma_int8 tmma_chk u_tmma_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .c_wr_en(c_wr_en), .c_wr_tile(c_wr_tile), .c_wr_row(c_wr_row)
);

// File: tb/tile_mma_int8_bench.sv
module tile_mma_int8_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]   t;
    logic [3:0]   r;
    logic [511:0] d;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] sel_a = '0, sel_b = '0, sel_c = '0;
  logic busy, done;
  logic [2:0] a_rd_tile, b_rd_tile, c_rd_tile, c_wr_tile;
  logic [3:0] a_rd_row, b_rd_row, c_rd_row, c_wr_row;
  logic [511:0] a_rd_data, b_rd_data, c_rd_data, c_wr_data;
  logic c_wr_en;

  logic         bw_en = 1'b0;
  logic [2:0]   bw_tile = '0;
  logic [3:0]   bw_row = '0;
  logic [511:0] bw_data = '0;

  logic [511:0] tiles [8][16];
  wr_item_t sbq[$];
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_mma_int8 u_tile_mma_int8 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .busy(busy), .done(done),
    .a_rd_tile(a_rd_tile), .a_rd_row(a_rd_row), .a_rd_data(a_rd_data),
    .b_rd_tile(b_rd_tile), .b_rd_row(b_rd_row), .b_rd_data(b_rd_data),
    .c_rd_tile(c_rd_tile), .c_rd_row(c_rd_row), .c_rd_data(c_rd_data),
    .c_wr_en(c_wr_en), .c_wr_tile(c_wr_tile), .c_wr_row(c_wr_row), .c_wr_data(c_wr_data)
  );

  assign a_rd_data = tiles[a_rd_tile][a_rd_row];
  assign b_rd_data = tiles[b_rd_tile][b_rd_row];
  assign c_rd_data = tiles[c_rd_tile][c_rd_row];

  always @(posedge clk) begin
    if (c_wr_en) tiles[c_wr_tile][c_wr_row] <= c_wr_data;
    else if (bw_en) tiles[bw_tile][bw_row] <= bw_data;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference per R4/R5/R6.
  function automatic logic [511:0] exp_row(input int ta, input int tb, input int tc, input int n);
    logic [511:0] res;
    for (int m = 0; m < 16; m++) begin
      logic signed [31:0] acc;
      acc = tiles[tc][n][m*32 +: 32];
      for (int j = 0; j < 64; j++) begin
        logic signed [7:0]  av, bv;
        logic signed [31:0] p;
        av = tiles[ta][n][j*8 +: 8];
        bv = tiles[tb][j/4][(m*4 + (j%4))*8 +: 8];
        p = 32'(av) * 32'(bv);
        acc = acc + p;
      end
      res[m*32 +: 32] = acc;
    end
    return res;
  endfunction

  // Monitor: pops the scoreboard on every write (R7 ordering/tile, R5 data).
  always @(negedge clk) begin
    if (rst_n && c_wr_en) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R3 unexpected write", {25'd0, c_wr_tile, c_wr_row}, 32'd0);
      end else begin
        wr_item_t e;
        int bad;
        e = sbq.pop_front();
        check(c_wr_tile == e.t && c_wr_row == e.r, "R7 write target",
              {25'd0, c_wr_tile, c_wr_row}, {25'd0, e.t, e.r});
        bad = -1;
        for (int m = 15; m >= 0; m--) if (c_wr_data[m*32 +: 32] !== e.d[m*32 +: 32]) bad = m;
        if (bad < 0) check(1'b1, "R5 row data", 32'd0, 32'd0);
        else check(1'b0, "R5/R6 row data", c_wr_data[bad*32 +: 32], e.d[bad*32 +: 32]);
      end
    end
  end

  task automatic fill(input int t, input int mode, input logic [31:0] v);
    for (int r = 0; r < 16; r++) begin
      logic [511:0] d;
      for (int w = 0; w < 16; w++)
        d[w*32 +: 32] = (mode == 0) ? $urandom : (mode == 1) ? {4{v[7:0]}} : v;
      @(negedge clk);
      bw_en = 1'b1; bw_tile = 3'(t); bw_row = 4'(r); bw_data = d;
    end
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic run_op(input int ta, input int tb, input int tc, input bit ign);
    int done_at;
    bit busy_at_done;
    for (int r = 0; r < 16; r++) begin
      wr_item_t it;
      it.t = 3'(tc); it.r = 4'(r); it.d = exp_row(ta, tb, tc, r);
      sbq.push_back(it);
    end
    @(negedge clk);
    sel_a = 3'(ta); sel_b = 3'(tb); sel_c = 3'(tc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sel_a = 3'd7; sel_b = 3'd7; sel_c = 3'd7;  // R2: later select changes must not matter
    check(busy == 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
    done_at = 0; busy_at_done = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      if (ign && i == 4) start = 1'b1;   // R3: start while busy
      if (ign && i == 5) start = 1'b0;
      @(negedge clk);
      if (done && done_at == 0) begin
        done_at = i;
        busy_at_done = busy;
      end
    end
    check(done_at == 33, "R8 done timing", 32'(done_at), 32'd33);
    check(busy_at_done == 1'b0, "R8 busy low at done", {31'd0, busy_at_done}, 32'd0);
    check(sbq.size() == 0, "R7 all rows written", 32'(sbq.size()), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] snap [16];
    repeat (3) @(negedge clk);
    check(!busy && !done && !c_wr_en, "R1 reset state", {29'd0, busy, done, c_wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !c_wr_en, "R1 after reset", {29'd0, busy, done, c_wr_en}, 32'd0);

    // R4/R5: random operands, random accumulators
    fill(1, 0, 0); fill(2, 0, 0); fill(3, 0, 0);
    run_op(1, 2, 3, 1'b0);

    // R5: all -128 gives +1048576 per element
    fill(4, 1, 32'h80); fill(5, 1, 32'h80); fill(6, 2, 32'h0);
    run_op(4, 5, 6, 1'b0);
    check(tiles[6][0][31:0] == 32'h0010_0000, "R5 -128x-128", tiles[6][0][31:0], 32'h0010_0000);

    // R6: +127 operands on 0x7FFFFFFF wrap
    fill(4, 1, 32'h7F); fill(5, 1, 32'h7F); fill(6, 2, 32'h7FFF_FFFF);
    run_op(4, 5, 6, 1'b0);
    check(tiles[6][15][511:480] == 32'h800F_C03F, "R6 wrap", tiles[6][15][511:480], 32'h800F_C03F);

    // R5: mixed signs
    fill(4, 1, 32'h80); fill(5, 1, 32'h7F); fill(6, 2, 32'h0);
    run_op(4, 5, 6, 1'b0);
    check(tiles[6][7][255:224] == 32'hFFF0_2000, "R5 -128x127", tiles[6][7][255:224], 32'hFFF0_2000);

    // R9 aliasing A==C, with R3 ignored start aimed at tile 7
    fill(1, 0, 0); fill(2, 0, 0); fill(7, 0, 0);
    for (int r = 0; r < 16; r++) snap[r] = tiles[7][r];
    run_op(1, 2, 1, 1'b1);
    begin
      int diff;
      diff = 0;
      for (int r = 0; r < 16; r++) if (tiles[7][r] !== snap[r]) diff++;
      check(diff == 0, "R3 ignored start left tile 7", 32'(diff), 32'd0);
    end

    // back-to-back operation on fresh data
    fill(0, 0, 0);
    run_op(0, 2, 3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule